// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the coherence controller that sits beside one processor in a small shared-bus multiprocessor. It owns a direct-mapped, write-back cache of single-word lines held in registers and keeps each line in one of three states. The states are Invalid (no data), Shared (clean and readable) and Exclusive (the only copy, writable and dirty). Read hits and write hits to Exclusive lines complete locally. Every other access needs the bus. The controller raises a bus request, waits for the grant and only then places its transaction and changes the line. The transaction is a read miss, a write miss or a write-back of a dirty victim.

All traffic from the other caches reaches the controller on the snoop inputs. A snooped write miss that matches a valid local line kills that line. A snooped read miss that matches a dirty line makes the controller drive the latest data and drop the line to Shared. Snoops are handled ahead of any local work in the same cycle. The bus is atomic: a granted transaction finishes in its grant cycle, and the fill data arrives on `bus_rdata` in that same cycle. The processor holds its request stable until `cpu_done` pulses.

Top module: `snoop_inval_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address goes to the bus. `cpu_done`, `bus_req`, `bus_out_valid` and `snp_supply` are all low while reset is held and right after it.
- R2: A read whose index holds a Shared or Exclusive line with a matching tag raises `cpu_done` for one cycle, one cycle after the request is seen. `cpu_rdata` then carries the stored word, and `bus_req` stays low. The index is `addr[IDX_W-1:0]` and the tag is the remaining upper bits.
- R3: A read miss raises `bus_req`. In the grant cycle it drives `bus_out_cmd`=1 (read miss) with the request address. It then fills the line as Shared with `bus_rdata` and returns that word.
- R4: A write to a Shared or Invalid line is a miss. In the grant cycle it drives `bus_out_cmd`=2 (write miss), and the line becomes Exclusive holding the written word. A write to an Exclusive line with a matching tag completes like a hit, without the bus.
- R5: While a miss waits for the grant, the line's state does not change unless a snoop changes it. A transaction appears on the bus only in a cycle where `bus_gnt` is high and no snoop is present.
- R6: A miss whose index holds an Exclusive line with another tag first issues `bus_out_cmd`=3 (write-back), carrying the old address and data. Only after that does it issue its own miss. A Shared victim is dropped without a write-back.
- R7: A snooped read miss (`snp_cmd`=1) that matches a local Exclusive line raises `snp_supply` in the same cycle, with the line's word on `snp_data`. The line becomes Shared, so a later local write needs the bus again.
- R8: A snooped write miss (`snp_cmd`=2) that matches a local Shared or Exclusive line makes it Invalid. An Exclusive line also supplies its data in that cycle.
- R9: A snooped read miss that matches a local Shared line leaves the line unchanged and gives no data response.
- R10: A snoop that arrives in the same cycle as a local request is applied first. A read of a line that the snoop invalidates therefore misses.
- R11: When another cache wins the bus for a write to a block that this cache also waits to write, the snooped write miss invalidates the local copy. The local write then issues its own write miss when granted and ends Exclusive with its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_out_valid | output | 1 | A transaction is placed on the bus this cycle |
| bus_out_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_out_addr | output | ADDR_W | Transaction address |
| bus_out_data | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data returned in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_out_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the dirty word this cycle |
| snp_data | output | DATA_W | Supplied word |

## Verification
A table of processor accesses drives read hits and misses, writes to Shared, Invalid and Exclusive lines, and conflict misses over both dirty and clean victims. For each access the number and kind of bus transactions tell a hit from a miss and a write-back from a clean drop. Snoops of each command are aimed at Shared, Exclusive and non-matching lines. A later local access, which either hits or needs the bus, exposes the state each snoop left behind. Timed snoops placed before a grant, or in the first cycle of a request, separate a controller that changes state early, or ignores snoop priority, from a correct one. The same timing reproduces the losing side of a write race.

// File: rtl/ccc_pkg.sv
// Shared encodings for the snooping cache controller.
// Assumes: bus and snoop command codes are common to every cache on the bus.
package ccc_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WBACK = 2'd1,
        SQ_MISS  = 2'd2,
        SQ_RESP  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/ccc_line_store.sv
// Register-based line store: state, tag and one data word per line.
// Two read ports (processor index, snoop index) and two update ports.
// Assumes: the snoop update only touches state and wins a same-line clash;
// the sequencer never updates in a snoop cycle, so no clash occurs in use.
module ccc_line_store
    import ccc_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(LINES)-1:0]  cpu_idx,
    output logic [1:0]                cpu_st,
    output logic [TAG_W-1:0]          cpu_tag,
    output logic [DATA_W-1:0]         cpu_data,
    input  logic [$clog2(LINES)-1:0]  snp_idx,
    output logic [1:0]                snp_st,
    output logic [TAG_W-1:0]          snp_tag,
    output logic [DATA_W-1:0]         snp_data,
    input  logic                      fill_we,
    input  logic [1:0]                fill_st,
    input  logic [TAG_W-1:0]          fill_tag,
    input  logic [DATA_W-1:0]         fill_data,
    input  logic                      sup_we,
    input  logic [1:0]                sup_st,
    output logic [2*LINES-1:0]        st_flat
);

    localparam int IW = $clog2(LINES);

    logic [TAG_W*LINES-1:0]  tag_flat;
    logic [DATA_W*LINES-1:0] data_flat;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [1:0]        st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;

        // Per-line register: snoop state change first, then sequencer write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LN_INV;
                tag_r <= '0;
                dat_r <= '0;
            end else if (sup_we && snp_idx == IW'(i)) begin
                st_r <= sup_st;
            end else if (fill_we && cpu_idx == IW'(i)) begin
                st_r  <= fill_st;
                tag_r <= fill_tag;
                dat_r <= fill_data;
            end
        end

        assign st_flat[2*i +: 2]             = st_r;
        assign tag_flat[TAG_W*i +: TAG_W]    = tag_r;
        assign data_flat[DATA_W*i +: DATA_W] = dat_r;
    end

    // Read ports: plain indexed selects.
    assign cpu_st   = st_flat[2*cpu_idx +: 2];
    assign cpu_tag  = tag_flat[TAG_W*cpu_idx +: TAG_W];
    assign cpu_data = data_flat[DATA_W*cpu_idx +: DATA_W];
    assign snp_st   = st_flat[2*snp_idx +: 2];
    assign snp_tag  = tag_flat[TAG_W*snp_idx +: TAG_W];
    assign snp_data = data_flat[DATA_W*snp_idx +: DATA_W];

endmodule

// File: rtl/ccc_snoop_unit.sv
// Snoop decoder: reacts to another cache's transaction on the local line.
// Assumes: a snooped write-back never matches a valid local line.
module ccc_snoop_unit
    import ccc_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [1:0]        line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              snp_hit,
    output logic              upd_we,
    output logic [1:0]        upd_st,
    output logic              supply,
    output logic [DATA_W-1:0] supply_data
);

    // Decide the state change and data response for one snooped command.
    always_comb begin
        snp_hit = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);
        upd_we  = 1'b0;
        upd_st  = line_st;
        supply  = 1'b0;
        if (snp_hit) begin
            case (snp_cmd)
                BC_RDMISS: begin
                    if (line_st == LN_EXC) begin
                        supply = 1'b1;
                        upd_we = 1'b1;
                        upd_st = LN_SHR;
                    end
                end
                BC_WRMISS: begin
                    supply = (line_st == LN_EXC);
                    upd_we = 1'b1;
                    upd_st = LN_INV;
                end
                default: ;
            endcase
        end
        supply_data = supply ? line_data : '0;
    end

endmodule

// File: rtl/ccc_req_seq.sv
// Request sequencer: serves processor accesses, arbitrates for the bus,
// issues write-back / read-miss / write-miss and fills the line.
// Assumes: atomic bus (fill data in the grant cycle), processor holds its
// request stable until cpu_done, grant never coincides with a snoop.
module ccc_req_seq
    import ccc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic [1:0]              line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    fill_we,
    output logic [1:0]              fill_st,
    output logic [DATA_W-1:0]       fill_data,
    input  logic                    snp_valid,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    bus_out_valid,
    output logic [1:0]              bus_out_cmd,
    output logic [ADDR_W-1:0]       bus_out_addr,
    output logic [DATA_W-1:0]       bus_out_data,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic [1:0]              seq_state
);

    localparam int TAG_W = ADDR_W - IDX_W;

    seq_st_e           st_q, st_n;
    logic [DATA_W-1:0] rdata_q, rdata_n;
    logic              rd_load;
    logic [TAG_W-1:0]  cpu_tag;
    logic              tag_eq, hit, go;

    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign tag_eq  = (line_tag == cpu_tag);
    assign hit     = (line_st != LN_INV) && tag_eq;
    assign go      = bus_gnt && !snp_valid;

    // Next state, bus transaction and line update for the current step.
    always_comb begin
        st_n          = st_q;
        bus_req       = 1'b0;
        bus_out_valid = 1'b0;
        bus_out_cmd   = BC_NONE;
        bus_out_addr  = cpu_addr;
        bus_out_data  = '0;
        fill_we       = 1'b0;
        fill_st       = LN_INV;
        fill_data     = cpu_wdata;
        rd_load       = 1'b0;
        rdata_n       = line_data;
        case (st_q)
            SQ_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    if (!cpu_we && hit) begin
                        rd_load = 1'b1;
                        st_n    = SQ_RESP;
                    end else if (cpu_we && hit && line_st == LN_EXC) begin
                        fill_we = 1'b1;
                        fill_st = LN_EXC;
                        st_n    = SQ_RESP;
                    end else if (line_st == LN_EXC && !tag_eq) begin
                        st_n = SQ_WBACK;
                    end else begin
                        st_n = SQ_MISS;
                    end
                end
            end
            SQ_WBACK: begin
                if (line_st != LN_EXC) begin
                    // A snoop already cleaned or killed the victim.
                    if (!snp_valid) st_n = SQ_MISS;
                end else begin
                    bus_req = 1'b1;
                    if (go) begin
                        bus_out_valid = 1'b1;
                        bus_out_cmd   = BC_WBACK;
                        bus_out_addr  = {line_tag, cpu_addr[IDX_W-1:0]};
                        bus_out_data  = line_data;
                        fill_we       = 1'b1;
                        fill_st       = LN_INV;
                        fill_data     = line_data;
                        st_n          = SQ_MISS;
                    end
                end
            end
            SQ_MISS: begin
                bus_req = 1'b1;
                if (go) begin
                    bus_out_valid = 1'b1;
                    bus_out_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
                    fill_we       = 1'b1;
                    fill_st       = cpu_we ? LN_EXC : LN_SHR;
                    fill_data     = cpu_we ? cpu_wdata : bus_rdata;
                    rd_load       = !cpu_we;
                    rdata_n       = bus_rdata;
                    st_n          = SQ_RESP;
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    // Sequencer state and returned read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            rdata_q <= '0;
        end else begin
            st_q <= st_n;
            if (rd_load) rdata_q <= rdata_n;
        end
    end

    assign cpu_done  = (st_q == SQ_RESP);
    assign cpu_rdata = rdata_q;
    assign seq_state = st_q;

endmodule

// File: rtl/snoop_inval_cache.sv
// Top: per-processor write-invalidate coherence controller for a
// direct-mapped write-back cache on an atomic shared bus.
// Assumes: snp_valid and bus_gnt are never high together.
module snoop_inval_cache
    import ccc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_out_valid,
    output logic [1:0]        bus_out_cmd,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [1:0]         cpu_line_st, snp_line_st, fill_st, sup_st, seq_state;
    logic [TAG_W-1:0]   cpu_line_tag, snp_line_tag;
    logic [DATA_W-1:0]  cpu_line_data, snp_line_data, fill_data;
    logic               fill_we, sup_we, snp_hit;
    logic [2*LINES-1:0] st_flat;

    ccc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_idx  (cpu_addr[IDX_W-1:0]),
        .cpu_st   (cpu_line_st),
        .cpu_tag  (cpu_line_tag),
        .cpu_data (cpu_line_data),
        .snp_idx  (snp_addr[IDX_W-1:0]),
        .snp_st   (snp_line_st),
        .snp_tag  (snp_line_tag),
        .snp_data (snp_line_data),
        .fill_we  (fill_we),
        .fill_st  (fill_st),
        .fill_tag (cpu_addr[ADDR_W-1:IDX_W]),
        .fill_data(fill_data),
        .sup_we   (sup_we),
        .sup_st   (sup_st),
        .st_flat  (st_flat)
    );

    ccc_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .line_st    (snp_line_st),
        .line_tag   (snp_line_tag),
        .line_data  (snp_line_data),
        .snp_hit    (snp_hit),
        .upd_we     (sup_we),
        .upd_st     (sup_st),
        .supply     (snp_supply),
        .supply_data(snp_data)
    );

    ccc_req_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_done     (cpu_done),
        .cpu_rdata    (cpu_rdata),
        .line_st      (cpu_line_st),
        .line_tag     (cpu_line_tag),
        .line_data    (cpu_line_data),
        .fill_we      (fill_we),
        .fill_st      (fill_st),
        .fill_data    (fill_data),
        .snp_valid    (snp_valid),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .bus_out_valid(bus_out_valid),
        .bus_out_cmd  (bus_out_cmd),
        .bus_out_addr (bus_out_addr),
        .bus_out_data (bus_out_data),
        .bus_rdata    (bus_rdata),
        .seq_state    (seq_state)
    );

endmodule

// File: rtl/snoop_inval_cache_chk.sv
// Protocol checker bound to the controller top.
// Assumes: the processor holds cpu_addr stable while a request is pending.
module snoop_inval_cache_chk
    import ccc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cpu_done,
    input logic                     bus_req,
    input logic                     bus_gnt,
    input logic                     bus_out_valid,
    input logic [1:0]               bus_out_cmd,
    input logic                     snp_valid,
    input logic [1:0]               snp_cmd,
    input logic [ADDR_W-1:0]        snp_addr,
    input logic                     snp_supply,
    input logic                     snp_hit,
    input logic [1:0]               seq_state,
    input logic [1:0]               cpu_line_st,
    input logic [2*(1<<IDX_W)-1:0]  st_flat
);

    logic [IDX_W-1:0] sidx_q;

    // Remember last cycle's snoop index to look up its updated state.
    always_ff @(posedge clk) sidx_q <= snp_addr[IDX_W-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!cpu_done && !bus_req && !bus_out_valid)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R2

    AST_TXN_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |-> (bus_gnt && bus_req && !snp_valid)); // R5

    AST_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_MISS && !bus_gnt && !snp_valid) |=> (cpu_line_st == $past(cpu_line_st))); // R5

    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out_valid && bus_out_cmd == BC_WBACK) |=> bus_req); // R6

    AST_SUPPLY_CLEANS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> (st_flat[2*sidx_q +: 2] != LN_EXC)); // R7

    AST_SNOOP_WR_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_cmd == BC_WRMISS) |=> (st_flat[2*sidx_q +: 2] == LN_INV)); // R8

endmodule

bind snoop_inval_cache snoop_inval_cache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_done     (cpu_done),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_out_valid(bus_out_valid),
    .bus_out_cmd  (bus_out_cmd),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd),
    .snp_addr     (snp_addr),
    .snp_supply   (snp_supply),
    .snp_hit      (snp_hit),
    .seq_state    (seq_state),
    .cpu_line_st  (cpu_line_st),
    .st_flat      (st_flat)
);

// File: tb/snoop_inval_cache_test.sv
`timescale 1ns/1ps
// Bench: table of processor accesses, then directed snoop, race and reset tests.
module snoop_inval_cache_test;

    localparam logic [1:0] C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cpu_req = 0, cpu_we = 0;
    logic [7:0] cpu_addr = 0, cpu_wdata = 0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req, bus_gnt = 0, bus_out_valid;
    logic [1:0] bus_out_cmd;
    logic [7:0] bus_out_addr, bus_out_data;
    logic [7:0] bus_rdata = 0;
    logic       snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [7:0] snp_addr = 0;
    logic       snp_supply;
    logic [7:0] snp_data;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    snoop_inval_cache uut (.*);

    typedef struct packed {
        logic       we;
        logic [7:0] addr, wd, fill;
        logic [1:0] n, c0;
        logic [7:0] a0, d0, rd;
    } vec_t;

    // index = addr[1:0], tag = addr[7:2]
    localparam vec_t TBL [10] = '{
        '{1'b0, 8'h10, 8'h00, 8'hA1, 2'd1, C_RD, 8'h10, 8'h00, 8'hA1},
        '{1'b0, 8'h10, 8'h00, 8'hEE, 2'd0, 2'd0, 8'h00, 8'h00, 8'hA1},
        '{1'b1, 8'h10, 8'h55, 8'hEE, 2'd1, C_WR, 8'h10, 8'h00, 8'h00},
        '{1'b1, 8'h10, 8'h66, 8'hEE, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00},
        '{1'b0, 8'h10, 8'h00, 8'hEE, 2'd0, 2'd0, 8'h00, 8'h00, 8'h66},
        '{1'b0, 8'h14, 8'h00, 8'hB2, 2'd2, C_WB, 8'h10, 8'h66, 8'hB2},
        '{1'b0, 8'h10, 8'h00, 8'h66, 2'd1, C_RD, 8'h10, 8'h00, 8'h66},
        '{1'b1, 8'h23, 8'h77, 8'hEE, 2'd1, C_WR, 8'h23, 8'h00, 8'h00},
        '{1'b0, 8'h23, 8'h00, 8'hEE, 2'd0, 2'd0, 8'h00, 8'h00, 8'h77},
        '{1'b0, 8'h13, 8'h00, 8'hC3, 2'd2, C_WB, 8'h23, 8'h77, 8'hC3}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One processor access; optional snoop at loop step snp_at (0 = with the
    // request), grant withheld until step gnt_after has passed.
    task automatic run_op(input logic we, input logic [7:0] a, input logic [7:0] wd,
                          input logic [7:0] fill, input int snp_at, input logic [1:0] scmd,
                          input logic [7:0] saddr, input int gnt_after,
                          output int ncmd, output logic [1:0] c0, output logic [7:0] a0,
                          output logic [7:0] d0, output logic [1:0] c1,
                          output logic [7:0] rd, output logic sup, output logic [7:0] sdat);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_rdata = fill;
        bus_gnt = 0; ncmd = 0; c0 = 0; a0 = 0; d0 = 0; c1 = 0; rd = 0; sup = 0; sdat = 0;
        if (snp_at == 0) begin
            snp_valid = 1; snp_cmd = scmd; snp_addr = saddr;
            #1 sup = snp_supply; sdat = snp_data;
        end
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            snp_valid = 0;
            if (cpu_done) begin
                rd = cpu_rdata;
                break;
            end
            if (i == snp_at) begin
                bus_gnt = 0;
                snp_valid = 1; snp_cmd = scmd; snp_addr = saddr;
                #1 sup = snp_supply; sdat = snp_data;
            end else begin
                bus_gnt = bus_req && (i > gnt_after);
                #1;
                if (bus_out_valid) begin
                    if (ncmd == 0) begin
                        c0 = bus_out_cmd; a0 = bus_out_addr; d0 = bus_out_data;
                    end else c1 = bus_out_cmd;
                    ncmd++;
                end
            end
        end
        cpu_req = 0; bus_gnt = 0; snp_valid = 0;
    endtask

    // A standalone snoop from another cache; samples the response.
    task automatic snoop(input logic [1:0] cmd, input logic [7:0] a,
                         output logic sup, output logic [7:0] sdat);
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd; snp_addr = a;
        #1 sup = snp_supply; sdat = snp_data;
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [1:0] c0, c1;
        logic [7:0] a0, d0, rd, sd;
        logic sup;
        string rq;

        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk(!cpu_done && !bus_req && !bus_out_valid && !snp_supply, "R1 reset outputs",
            {cpu_done, bus_req, bus_out_valid, snp_supply}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!cpu_done && !bus_req, "R1 after reset", {cpu_done, bus_req}, 0);

        // Table walk: hits, misses, write to Shared/Exclusive, write-backs
        foreach (TBL[k]) begin
            run_op(TBL[k].we, TBL[k].addr, TBL[k].wd, TBL[k].fill, -1, 2'd0, 8'h0, 0,
                   n, c0, a0, d0, c1, rd, sup, sd);
            if (TBL[k].n == 2) rq = "R6";
            else if (TBL[k].n == 0) rq = TBL[k].we ? "R4 write hit" : "R2";
            else rq = TBL[k].we ? "R4" : "R3";
            chk(n == int'(TBL[k].n), rq, n, TBL[k].n);
            if (TBL[k].n != 0)
                chk(c0 == TBL[k].c0 && a0 == TBL[k].a0, rq, {c0, a0}, {TBL[k].c0, TBL[k].a0});
            if (TBL[k].n == 2)
                chk(d0 == TBL[k].d0 && c1 == C_RD, "R6 wb data", {d0, c1}, {TBL[k].d0, C_RD});
            if (!TBL[k].we)
                chk(rd == TBL[k].rd, rq, rd, TBL[k].rd);
        end

        // R9: snooped read on Shared line: no supply, still a hit
        snoop(C_RD, 8'h10, sup, sd);
        chk(!sup, "R9 no supply", sup, 0);
        run_op(0, 8'h10, 0, 8'hEE, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 0 && rd == 8'h66, "R9 line kept", {n[7:0], rd}, {8'd0, 8'h66});

        // R8: snooped write on Shared line invalidates it
        snoop(C_WR, 8'h10, sup, sd);
        chk(!sup, "R8 shared no supply", sup, 0);
        run_op(0, 8'h10, 0, 8'h99, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && c0 == C_RD && rd == 8'h99, "R8 read misses", {n[7:0], rd}, {8'd1, 8'h99});

        // R7: dirty line supplies on snooped read and becomes Shared
        run_op(1, 8'h21, 8'h5A, 8'hEE, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && c0 == C_WR, "R4 write from Invalid", {n[7:0], c0}, {8'd1, C_WR});
        snoop(C_RD, 8'h21, sup, sd);
        chk(sup && sd == 8'h5A, "R7 supply", {sup, sd}, {1'b1, 8'h5A});
        run_op(1, 8'h21, 8'h5B, 8'hEE, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && c0 == C_WR, "R7 now Shared, write misses", {n[7:0], c0}, {8'd1, C_WR});
        snoop(C_WR, 8'h21, sup, sd);
        chk(sup && sd == 8'h5B, "R8 dirty supply", {sup, sd}, {1'b1, 8'h5B});
        run_op(0, 8'h21, 0, 8'h31, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && rd == 8'h31, "R8 dirty invalidated", {n[7:0], rd}, {8'd1, 8'h31});

        // R5: line stays Shared while the grant is withheld
        run_op(1, 8'h10, 8'h42, 8'hEE, 3, C_RD, 8'h10, 4, n, c0, a0, d0, c1, rd, sup, sd);
        chk(!sup, "R5 no early Exclusive", sup, 0);
        chk(n == 1 && c0 == C_WR && a0 == 8'h10, "R5 write miss after grant",
            {n[7:0], c0}, {8'd1, C_WR});
        snoop(C_RD, 8'h10, sup, sd);
        chk(sup && sd == 8'h42, "R5 Exclusive after grant", {sup, sd}, {1'b1, 8'h42});

        // R10: snoop in the request's first cycle wins over the lookup
        run_op(0, 8'h10, 0, 8'h88, 0, C_WR, 8'h10, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && c0 == C_RD && rd == 8'h88, "R10 snoop first", {n[7:0], rd}, {8'd1, 8'h88});

        // R11: lose the write race, get invalidated, then win with own data
        run_op(1, 8'h13, 8'hE1, 8'hEE, 2, C_WR, 8'h13, 3, n, c0, a0, d0, c1, rd, sup, sd);
        chk(!sup, "R11 loser held Shared", sup, 0);
        chk(n == 1 && c0 == C_WR && a0 == 8'h13, "R11 own write miss", {n[7:0], c0}, {8'd1, C_WR});
        snoop(C_RD, 8'h13, sup, sd);
        chk(sup && sd == 8'hE1, "R11 ends Exclusive", {sup, sd}, {1'b1, 8'hE1});

        // R1: reset mid-run empties the cache
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        chk(!cpu_done && !bus_req, "R1 reset again", {cpu_done, bus_req}, 0);
        rst_n = 1;
        run_op(0, 8'h21, 0, 8'h44, -1, 0, 0, 0, n, c0, a0, d0, c1, rd, sup, sd);
        chk(n == 1 && rd == 8'h44, "R1 all Invalid", {n[7:0], rd}, {8'd1, 8'h44});

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule